// File: doc/BRIEF.md
# Three-Voice Phase-Accumulator Tone Oscillator

This block holds three tone oscillators that all step on the same clock. Each oscillator keeps a 24-bit phase accumulator, a 23-bit pseudo-random noise register and its own waveform shaping logic. On every clock, each oscillator presents a 12-bit sample. The sample can be a sawtooth, a triangle, a pulse, noise, or a bitwise combination of the first three. Software loads each oscillator's 16-bit frequency word, its 12-bit pulse threshold and its control byte through byte-wide writes. The control byte picks the waveform and sets the test, ring-modulation and hard-sync bits.

The oscillators are joined in a ring. Oscillator 0 takes oscillator 2 as its partner, oscillator 1 takes oscillator 0, and oscillator 2 takes oscillator 1. The partner serves two purposes. Its rising accumulator MSB can restart this oscillator (hard sync). Its MSB can also fold this oscillator's triangle (ring modulation). An 8-bit readback port shows the upper bits of the last oscillator's sample, so software can use that voice as a modulation source.

Top module: `tone_osc_trio`

## Requirements
- R1: After reset, every accumulator is 0, every noise register holds 0x7FFFF8, and the frequency, pulse-width and control registers are 0. All samples and the readback are 0 until a new select is written.
- R2: On each clock, a running oscillator's accumulator advances by its frequency word, modulo 2^24. Waveform select 2 (bit 1) outputs the sawtooth, which is accumulator bits 23:12.
- R3: Waveform select 1 (bit 0) outputs the triangle. This is accumulator bits 22:11, inverted when the fold bit is 1. The fold bit is accumulator bit 23 when control bit 2 (ring) is clear. When ring is set, it is accumulator bit 23 XOR the partner's accumulator bit 23.
- R4: Waveform select 4 (bit 2) outputs the pulse. It is 0xFFF while test is set or while accumulator bits 23:12 are at least the pulse width. Otherwise it is 0x000.
- R5: The noise register shifts left by one on each clock in which accumulator bit 19 goes from 0 to 1. The new bit 0 is old bit 22 XOR old bit 17. Select 8 (bit 3) outputs register bits 22, 20, 16, 13, 11, 7, 4 and 2 on sample bits 11 down to 4, with bits 3:0 zero. The reset seed therefore gives 0xFE0.
- R6: Writing control bit 3 (test) as 1 zeroes the accumulator and the noise register at that edge. Both stay at zero while test remains set. A control write that clears test loads the noise register with 0x7FFFF8 and leaves the accumulator at 0, and counting resumes on the following edge.
- R7: If the partner's accumulator bit 23 goes from 0 to 1 on a clock and this oscillator has control bit 1 (sync) set, this oscillator's accumulator is loaded with 0 on that clock instead of its sum. This restart is suppressed when the partner is itself being restarted on the same clock (its own sync is set and its own partner's MSB rises). Select, test, ring and sync come from the control value held before that edge.
- R8: Selects 3, 5, 6 and 7 output the bitwise AND of their component waveforms. Select 0, and every select with bit 3 set plus any of bits 2:0, outputs 0.
- R9: The readback port always equals bits 11:4 of oscillator 2's current sample.
- R10: A write with register code 0/1 loads the frequency low/high byte, code 2/3 loads the pulse-width low byte and the low 4 bits of the high byte, and code 4 loads the control byte, where bits 7:4 are the select and bit 0 is unused. The selected oscillator is given by the voice field (3 selects none). The new value is used from the clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrVoice | input | 2 | Oscillator addressed by the write (0..2) |
| wrSel | input | 3 | Register code: 0 freq low, 1 freq high, 2 pw low, 3 pw high, 4 control |
| wrData | input | 8 | Write data byte |
| waveBus | output | 36 | Samples; oscillator n on bits 12n+11:12n |
| oscRead | output | 8 | Bits 11:4 of oscillator 2's sample |

## Verification
The bench runs a cycle-accurate reference model of all three oscillators and compares every sample on every clock. Directed cases target the corner cases. One is a frequency word of 0xFFFF driven past the 2^24 wrap; a design that lost the carry would make the sawtooth restart too early. Another holds test for several cycles and then releases it; a design that skipped the reseed would leave the noise output stuck at zero. In a further case, both the partner and the partner's partner cross their MSB on the same clock; a design that ignored the suppression rule would restart the third oscillator and pull its sawtooth back to zero. Random writes to every register, including the unused voice code 3, also exercise triangle folding under ring modulation and every combined-select code.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int NUM_OSC  = 3;
  localparam int ACC_W    = 24;
  localparam int FREQ_W   = 16;
  localparam int PW_W     = 12;
  localparam int WAVE_W   = 12;
  localparam int NOISE_W  = 23;
  localparam int SEL_W    = 4;
  localparam int BYTE_W   = 8;
  localparam int VSEL_W   = $clog2(NUM_OSC + 1);
  localparam int NOISE_TAP_HI = 22;
  localparam int NOISE_TAP_LO = 17;
  localparam int NOISE_CLK_BIT = 19;
  localparam logic [NOISE_W-1:0] NOISE_SEED = 23'h7FFFF8;

  typedef enum logic [2:0] {
    REG_FREQ_LO = 3'd0,
    REG_FREQ_HI = 3'd1,
    REG_PW_LO   = 3'd2,
    REG_PW_HI   = 3'd3,
    REG_CTRL    = 3'd4
  } regSel_e;

  typedef struct packed {
    logic [NUM_OSC-1:0] testSet;
    logic [NUM_OSC-1:0] testClr;
  } oscStrobe_t;
endpackage

// File: rtl/osc_ctrl.sv
module osc_ctrl
  import osc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [VSEL_W-1:0]                wrVoice,
  input  logic [2:0]                       wrSel,
  input  logic [BYTE_W-1:0]                wrData,
  output logic [NUM_OSC-1:0][FREQ_W-1:0]   freq,
  output logic [NUM_OSC-1:0][PW_W-1:0]     pw,
  output logic [NUM_OSC-1:0][SEL_W-1:0]    waveSel,
  output logic [NUM_OSC-1:0]               testHold,
  output logic [NUM_OSC-1:0]               ringEn,
  output logic [NUM_OSC-1:0]               syncEn,
  output oscStrobe_t                       strobe
);
  localparam int PW_HI_W = PW_W - BYTE_W;

  for (genvar v = 0; v < NUM_OSC; v++) begin : g_voice
    logic hitVoice;
    logic ctrlWr;
    logic [FREQ_W-1:0] freqQ;
    logic [PW_W-1:0]   pwQ;
    logic [SEL_W-1:0]  selQ;
    logic              testQ, ringQ, syncQ;

    assign hitVoice = wrEn && (wrVoice == VSEL_W'(v));
    assign ctrlWr   = hitVoice && (wrSel == REG_CTRL);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        freqQ <= '0;
        pwQ   <= '0;
        selQ  <= '0;
        testQ <= 1'b0;
        ringQ <= 1'b0;
        syncQ <= 1'b0;
      end else if (hitVoice) begin
        case (wrSel)
          REG_FREQ_LO: freqQ[BYTE_W-1:0]      <= wrData;
          REG_FREQ_HI: freqQ[FREQ_W-1:BYTE_W] <= wrData;
          REG_PW_LO:   pwQ[BYTE_W-1:0]        <= wrData;
          REG_PW_HI:   pwQ[PW_W-1:BYTE_W]     <= wrData[PW_HI_W-1:0];
          REG_CTRL: begin
            selQ  <= wrData[7:4];
            testQ <= wrData[3];
            ringQ <= wrData[2];
            syncQ <= wrData[1];
          end
          default: ;
        endcase
      end
    end

    assign freq[v]           = freqQ;
    assign pw[v]             = pwQ;
    assign waveSel[v]        = selQ;
    assign testHold[v]       = testQ;
    assign ringEn[v]         = ringQ;
    assign syncEn[v]         = syncQ;
    assign strobe.testSet[v] = ctrlWr && wrData[3];
    assign strobe.testClr[v] = ctrlWr && !wrData[3] && testQ;
  end
endmodule

// File: rtl/osc_wave_shaper.sv
module osc_wave_shaper
  import osc_pkg::*;
(
  input  logic [ACC_W-1:0]   acc,
  input  logic               partnerMsb,
  input  logic               ringEn,
  input  logic               testHold,
  input  logic [PW_W-1:0]    pw,
  input  logic [NOISE_W-1:0] noise,
  input  logic [SEL_W-1:0]   waveSel,
  output logic [WAVE_W-1:0]  wave
);
  logic [WAVE_W-1:0] triWave, sawWave, pulseWave, noiseWave;
  logic [WAVE_W-1:0] triTerm, sawTerm, pulseTerm;
  logic              foldBit;

  assign foldBit   = acc[ACC_W-1] ^ (ringEn & partnerMsb);
  assign triWave   = foldBit ? ~acc[ACC_W-2 -: WAVE_W] : acc[ACC_W-2 -: WAVE_W];
  assign sawWave   = acc[ACC_W-1 -: WAVE_W];
  assign pulseWave = (testHold || (sawWave >= pw)) ? '1 : '0;
  assign noiseWave = {noise[22], noise[20], noise[16], noise[13],
                      noise[11], noise[7], noise[4], noise[2], 4'b0000};

  assign triTerm   = waveSel[0] ? triWave   : '1;
  assign sawTerm   = waveSel[1] ? sawWave   : '1;
  assign pulseTerm = waveSel[2] ? pulseWave : '1;

  always_comb begin
    if (waveSel[3]) wave = (waveSel[2:0] == 3'b000) ? noiseWave : '0;
    else if (waveSel[2:0] == 3'b000) wave = '0;
    else wave = triTerm & sawTerm & pulseTerm;
  end
endmodule

// File: rtl/osc_datapath.sv
module osc_datapath
  import osc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_OSC-1:0][FREQ_W-1:0]   freq,
  input  logic [NUM_OSC-1:0][PW_W-1:0]     pw,
  input  logic [NUM_OSC-1:0][SEL_W-1:0]    waveSel,
  input  logic [NUM_OSC-1:0]               testHold,
  input  logic [NUM_OSC-1:0]               ringEn,
  input  logic [NUM_OSC-1:0]               syncEn,
  input  oscStrobe_t                       strobe,
  output logic [NUM_OSC-1:0][ACC_W-1:0]    acc,
  output logic [NUM_OSC-1:0][NOISE_W-1:0]  noise,
  output logic [NUM_OSC-1:0]               syncHit,
  output logic [NUM_OSC-1:0][WAVE_W-1:0]   wave
);
  logic [NUM_OSC-1:0] msbRise;

  for (genvar v = 0; v < NUM_OSC; v++) begin : g_osc
    localparam int SRC  = (v + NUM_OSC - 1) % NUM_OSC;
    localparam int SRC2 = (v + 2 * NUM_OSC - 2) % NUM_OSC;

    logic [ACC_W-1:0]   accQ, accSum;
    logic [NOISE_W-1:0] noiseQ;
    logic               running, noiseStep;

    assign accSum    = accQ + ACC_W'(freq[v]);
    assign running   = !testHold[v] && !strobe.testSet[v];
    assign msbRise[v] = running && !accQ[ACC_W-1] && accSum[ACC_W-1];
    assign noiseStep = !accQ[NOISE_CLK_BIT] && accSum[NOISE_CLK_BIT];
    assign syncHit[v] = msbRise[SRC] && syncEn[v] && !(syncEn[SRC] && msbRise[SRC2]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ   <= '0;
        noiseQ <= NOISE_SEED;
      end else begin
        accQ <= (!running || syncHit[v]) ? '0 : accSum;
        if (strobe.testSet[v])      noiseQ <= '0;
        else if (strobe.testClr[v]) noiseQ <= NOISE_SEED;
        else if (testHold[v])       noiseQ <= '0;
        else if (noiseStep)
          noiseQ <= {noiseQ[NOISE_W-2:0], noiseQ[NOISE_TAP_HI] ^ noiseQ[NOISE_TAP_LO]};
      end
    end

    osc_wave_shaper u_shaper (
      .acc       (accQ),
      .partnerMsb(acc[SRC][ACC_W-1]),
      .ringEn    (ringEn[v]),
      .testHold  (testHold[v]),
      .pw        (pw[v]),
      .noise     (noiseQ),
      .waveSel   (waveSel[v]),
      .wave      (wave[v])
    );

    assign acc[v]   = accQ;
    assign noise[v] = noiseQ;
  end
endmodule

// File: rtl/tone_osc_trio.sv
module tone_osc_trio
  import osc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [VSEL_W-1:0]           wrVoice,
  input  logic [2:0]                  wrSel,
  input  logic [BYTE_W-1:0]           wrData,
  output logic [NUM_OSC*WAVE_W-1:0]   waveBus,
  output logic [BYTE_W-1:0]           oscRead
);
  logic [NUM_OSC-1:0][FREQ_W-1:0]  freq;
  logic [NUM_OSC-1:0][PW_W-1:0]    pw;
  logic [NUM_OSC-1:0][SEL_W-1:0]   waveSel;
  logic [NUM_OSC-1:0]              testHold, ringEn, syncEn, syncHit;
  logic [NUM_OSC-1:0][ACC_W-1:0]   acc;
  logic [NUM_OSC-1:0][NOISE_W-1:0] noise;
  logic [NUM_OSC-1:0][WAVE_W-1:0]  wave;
  oscStrobe_t                      strobe;

  osc_ctrl u_ctrl (
    .clk, .rstN, .wrEn, .wrVoice, .wrSel, .wrData,
    .freq, .pw, .waveSel, .testHold, .ringEn, .syncEn, .strobe
  );

  osc_datapath u_dp (
    .clk, .rstN, .freq, .pw, .waveSel, .testHold, .ringEn, .syncEn, .strobe,
    .acc, .noise, .syncHit, .wave
  );

  assign waveBus = wave;
  assign oscRead = wave[NUM_OSC-1][WAVE_W-1 -: BYTE_W];
endmodule

// File: rtl/tone_osc_trio_chk.sv
module tone_osc_trio_chk
  import osc_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_OSC-1:0]               testHold,
  input logic [NUM_OSC-1:0]               syncHit,
  input oscStrobe_t                       strobe,
  input logic [NUM_OSC-1:0][ACC_W-1:0]    acc,
  input logic [NUM_OSC-1:0][NOISE_W-1:0]  noise,
  input logic [NUM_OSC-1:0][FREQ_W-1:0]   freq,
  input logic [NUM_OSC-1:0][SEL_W-1:0]    waveSel,
  input logic [NUM_OSC*WAVE_W-1:0]        waveBus
);
  for (genvar v = 0; v < NUM_OSC; v++) begin : g_chk
    AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
      (!testHold[v] && !strobe.testSet[v] && !syncHit[v]) |=>
        acc[v] == ACC_W'($past(acc[v]) + ACC_W'($past(freq[v])))); // R2
    AST_TEST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
      (testHold[v] || strobe.testSet[v]) |=> acc[v] == '0); // R6
    AST_TEST_RESEED: assert property (@(posedge clk) disable iff (!rstN)
      strobe.testClr[v] |=> noise[v] == NOISE_SEED); // R6
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      syncHit[v] |=> acc[v] == '0); // R7
    AST_PULSE_TEST: assert property (@(posedge clk) disable iff (!rstN)
      (testHold[v] && waveSel[v] == 4'h4) |-> waveBus[v*WAVE_W +: WAVE_W] == '1); // R4
    AST_NOISE_COMBO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (waveSel[v][3] && waveSel[v][2:0] != 3'b000) |-> waveBus[v*WAVE_W +: WAVE_W] == '0); // R8
  end
endmodule

bind tone_osc_trio tone_osc_trio_chk u_chk (
  .clk(clk), .rstN(rstN), .testHold(testHold), .syncHit(syncHit), .strobe(strobe),
  .acc(acc), .noise(noise), .freq(freq), .waveSel(waveSel), .waveBus(waveBus)
);

// File: tb/test_tone_osc_trio.sv
`timescale 1ns/1ps
module test_tone_osc_trio;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0]  wrVoice = '0;
  logic [2:0]  wrSel = '0;
  logic [7:0]  wrData = '0;
  logic [35:0] waveBus;
  logic [7:0]  oscRead;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [23:0] mAcc[3];
  logic [22:0] mNoise[3];
  logic [15:0] mFreq[3];
  logic [11:0] mPw[3];
  logic [3:0]  mSel[3];
  logic        mTest[3], mRing[3], mSync[3];

  tone_osc_trio i_tone_osc_trio (.clk, .rstN, .wrEn, .wrVoice, .wrSel, .wrData,
                                 .waveBus, .oscRead);

  always #2.5 clk = ~clk;

  function automatic logic [11:0] refWave(int v);
    logic [11:0] tri_, saw, pul, noi, r;
    logic fold;
    int s = (v + 2) % 3;
    saw  = mAcc[v][23:12];
    fold = mAcc[v][23] ^ (mRing[v] & mAcc[s][23]);
    tri_ = fold ? ~mAcc[v][22:11] : mAcc[v][22:11];
    pul  = (mTest[v] || saw >= mPw[v]) ? 12'hFFF : 12'h000;
    noi  = {mNoise[v][22], mNoise[v][20], mNoise[v][16], mNoise[v][13],
            mNoise[v][11], mNoise[v][7], mNoise[v][4], mNoise[v][2], 4'h0};
    case (mSel[v])
      4'h1: r = tri_;
      4'h2: r = saw;
      4'h3: r = tri_ & saw;
      4'h4: r = pul;
      4'h5: r = pul & tri_;
      4'h6: r = pul & saw;
      4'h7: r = pul & tri_ & saw;
      4'h8: r = noi;
      default: r = 12'h000;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    for (int v = 0; v < 3; v++) check(tag, 32'(waveBus[v*12 +: 12]), 32'(refWave(v)));
    check("R9 readback", 32'(oscRead), 32'(refWave(2) >> 4));
  endtask

  task automatic modelReset();
    for (int v = 0; v < 3; v++) begin
      mAcc[v] = '0; mNoise[v] = 23'h7FFFF8; mFreq[v] = '0; mPw[v] = '0;
      mSel[v] = '0; mTest[v] = 0; mRing[v] = 0; mSync[v] = 0;
    end
  endtask

  task automatic modelStep();
    logic [23:0] sum[3], nAcc[3];
    logic [22:0] nNoise[3];
    logic rise[3], run[3], setS[3], clrS[3], hit[3];
    for (int v = 0; v < 3; v++) begin
      logic cw = wrEn && wrVoice == 2'(v) && wrSel == 3'd4;
      setS[v] = cw && wrData[3];
      clrS[v] = cw && !wrData[3] && mTest[v];
      run[v]  = !mTest[v] && !setS[v];
      sum[v]  = mAcc[v] + {8'h00, mFreq[v]};
      rise[v] = run[v] && !mAcc[v][23] && sum[v][23];
    end
    for (int v = 0; v < 3; v++) begin
      int s = (v + 2) % 3, s2 = (v + 1) % 3;
      hit[v]  = rise[s] && mSync[v] && !(mSync[s] && rise[s2]);
      nAcc[v] = (!run[v] || hit[v]) ? 24'h0 : sum[v];
      if (setS[v]) nNoise[v] = '0;
      else if (clrS[v]) nNoise[v] = 23'h7FFFF8;
      else if (mTest[v]) nNoise[v] = '0;
      else if (!mAcc[v][19] && sum[v][19])
        nNoise[v] = {mNoise[v][21:0], mNoise[v][22] ^ mNoise[v][17]};
      else nNoise[v] = mNoise[v];
    end
    for (int v = 0; v < 3; v++) begin
      mAcc[v] = nAcc[v]; mNoise[v] = nNoise[v];
    end
    if (wrEn && wrVoice != 2'd3) begin
      case (wrSel)
        3'd0: mFreq[wrVoice][7:0]  = wrData;
        3'd1: mFreq[wrVoice][15:8] = wrData;
        3'd2: mPw[wrVoice][7:0]    = wrData;
        3'd3: mPw[wrVoice][11:8]   = wrData[3:0];
        3'd4: begin
          mSel[wrVoice] = wrData[7:4]; mTest[wrVoice] = wrData[3];
          mRing[wrVoice] = wrData[2]; mSync[wrVoice] = wrData[1];
        end
        default: ;
      endcase
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    wrEn = 1'b0;
    compareAll(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic wr(int v, int sel, logic [7:0] d, string tag);
    wrEn = 1'b1; wrVoice = 2'(v); wrSel = 3'(sel); wrData = d;
    cycle(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    @(posedge clk); @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1 reset");
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    @(negedge clk);
    doReset();
    check("R1 readback after reset", 32'(oscRead), 32'h0);

    // R5: seed shown on the noise output
    wr(0, 4, 8'h80, "R5 noise seed");
    check("R5 seed taps", 32'(waveBus[11:0]), 32'hFE0);

    // R10 and R2: byte writes, sawtooth
    wr(0, 0, 8'h34, "R10 freq lo");
    wr(0, 1, 8'h12, "R10 freq hi");
    wr(0, 4, 8'h20, "R2 saw");
    idle(200, "R2 saw run");
    // R10: pw high keeps only 4 bits
    wr(1, 2, 8'h00, "R10 pw lo");
    wr(1, 3, 8'hFF, "R10 pw hi");
    wr(1, 4, 8'h40, "R4 pulse");
    check("R10 pw high nibble", 32'(waveBus[23:12]), 32'h000);
    wr(1, 1, 8'h90, "R10 freq");
    idle(300, "R4 pulse run");

    // R2 wrap with max frequency
    wr(0, 0, 8'hFF, "R2 max lo");
    wr(0, 1, 8'hFF, "R2 max hi");
    idle(600, "R2 wrap");

    // R3 triangle with and without ring
    wr(2, 0, 8'h77, "R3 partner");
    wr(2, 1, 8'h31, "R3 partner");
    wr(2, 4, 8'h20, "R3 partner saw");
    wr(0, 4, 8'h10, "R3 tri plain");
    idle(400, "R3 tri plain");
    wr(0, 4, 8'h14, "R3 tri ring");
    idle(800, "R3 tri ring");

    // R6 test freeze and reseed
    wr(1, 4, 8'h48, "R6 test set");
    check("R4 pulse under test", 32'(waveBus[23:12]), 32'hFFF);
    idle(20, "R6 held");
    wr(1, 4, 8'h28, "R6 saw under test");
    check("R6 acc held", 32'(waveBus[23:12]), 32'h000);
    wr(1, 4, 8'h80, "R6 test clear");
    check("R6 reseed", 32'(waveBus[23:12]), 32'hFE0);

    // R5 noise running
    wr(1, 0, 8'hFF, "R5 freq");
    wr(1, 1, 8'hFF, "R5 freq");
    idle(3000, "R5 noise run");

    // R8 every select value
    for (int s = 0; s < 16; s++) begin
      wr(0, 4, 8'(s << 4), "R8 select");
      idle(150, "R8 select");
    end

    // R7 hard sync with the suppression case
    doReset();
    wr(0, 4, 8'h2A, "R7 setup");
    wr(1, 4, 8'h28, "R7 setup");
    wr(2, 4, 8'h2A, "R7 setup");
    wr(0, 0, 8'h00, "R7 setup");
    wr(0, 1, 8'h01, "R7 setup");
    wr(1, 1, 8'h80, "R7 setup");
    wr(2, 0, 8'h81, "R7 setup");
    wr(2, 1, 8'h80, "R7 setup");
    wr(0, 4, 8'h22, "R7 release");
    wr(1, 4, 8'h20, "R7 release");
    wr(2, 4, 8'h22, "R7 release");
    idle(300, "R7 same-cycle rise");
    check("R7 osc0 not restarted", 32'(waveBus[11:0] != 12'h000), 32'h1);
    wr(1, 4, 8'h22, "R7 chain");
    idle(1500, "R7 ring sync");

    // Random mix covering all requirements
    doReset();
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(2) == 0) begin
        int sel = $urandom_range(4);
        logic [7:0] d = 8'($urandom);
        if (sel == 4 && $urandom_range(7) != 0) d[3] = 1'b0;
        wr($urandom_range(3), sel, d, "R10 random");
      end else cycle("R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule